// File: doc/BRIEF.md
# Home directory coherence controller

This block sits at the home node of a 16-node shared-memory machine and owns the directory for the memory blocks that live there. Each block has a directory entry holding one dirty flag and a presence vector with one bit per node. Together these encode three remote states. Uncached means the flag is clear and the vector is empty. Shared means the flag is clear and one or more bits are set. Dirty means the flag is set and exactly one bit, the owner, is set.

Every coherence request that reaches the home node carries an opcode, a block index and the id of the node that sent it. The block reads the matching entry, picks one action, and writes the new entry back in the same cycle. The possible actions are a data reply, an ownership grant, a write-back acknowledgement, a negative acknowledgement, a forward to the current owner, or a series of invalidations to the sharers. Replies leave on one output channel. Forwards and invalidations leave on a second channel. The two channels are independent, so a stalled reply channel only holds back the requests that actually need it.

While a forwarded operation is waiting for the owner to complete it, the entry is marked busy. Any other read, read-exclusive or write-back to that block is refused with a negative acknowledgement until the owner reports completion. Data payloads, the network and local snooping are handled elsewhere.

Top module: `home_dir_ctrl`

## Requirements
- R1: After reset every entry is uncached with an empty vector and not busy. Both output channels are idle, and a request is accepted in the first cycle its channel can take the answer.
- R2: A read (op 0) to a block that is not dirty and not busy puts a data reply (type 0) to the requester on the reply channel. It also adds the requester to the presence vector.
- R3: A read to a dirty, non-busy block puts a read forward (type 4) on the request channel. The forward goes to the owner, carries the requester id, and marks the block busy.
- R4: A completion (op 3) from the owner of a block busy with a read forward makes the block shared. Both the old owner and the waiting requester are then marked.
- R5: A read-exclusive (op 1) to a block that is not dirty and not busy returns a grant (type 1) to the requester on the reply channel. It then sends one invalidation (type 6) per marked sharer other than the requester, carrying the requester id, one per cycle in ascending node order. The block becomes dirty with only the requester marked.
- R6: A read-exclusive to a dirty, non-busy block puts an exclusive forward (type 5) on the request channel, addressed to the owner, and marks the block busy. The owner's completion (op 3) makes the requester the sole marked owner.
- R7: A write-back (op 2) from the owner of a dirty, non-busy block returns a write-back acknowledgement (type 3) and leaves the block uncached. A write-back from any other node, or to a block that is not dirty, gets a negative acknowledgement (type 2).
- R8: A read, read-exclusive or write-back to a busy block gets a negative acknowledgement to the sender and leaves the entry unchanged. Requests to other blocks proceed normally.
- R9: A completion that arrives for a non-busy block, or from a node that is not the owner, produces no message and leaves the entry unchanged.
- R10: Reply types (0 to 3) appear only on the reply channel and request types (4 to 6) only on the request channel. A message is held stable while its channel is not ready. A blocked reply channel does not stop a request that needs only the request channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Incoming request present |
| req_ready | output | 1 | Request taken at this edge |
| req_op | input | 2 | 0 read, 1 read-exclusive, 2 write-back, 3 completion |
| req_blk | input | 6 | Block index |
| req_src | input | 4 | Sending node id |
| rp_valid | output | 1 | Reply message present |
| rp_ready | input | 1 | Reply channel can take a message |
| rp_type | output | 3 | 0 data, 1 grant, 2 negative ack, 3 write-back ack |
| rp_dest | output | 4 | Node receiving the reply |
| rp_blk | output | 6 | Block index of the reply |
| rq_valid | output | 1 | Request-channel message present |
| rq_ready | input | 1 | Request channel can take a message |
| rq_type | output | 3 | 4 read forward, 5 exclusive forward, 6 invalidation |
| rq_dest | output | 4 | Node receiving the message |
| rq_blk | output | 6 | Block index of the message |
| rq_req | output | 4 | Node on whose behalf the message is sent |

## Verification
The checker watches the channel rules on every cycle. Each message type stays on its own channel, and held messages stay stable under back-pressure. No invalidation is addressed to the node it serves. Every accepted non-completion request produces an output message on the next cycle. Every directory write that sets the dirty flag carries exactly one presence bit.

Whether the right sharers are invalidated, whether the owner changes hands correctly, and whether busy blocks refuse and later release requests all depend on earlier traffic to the same block. Only the bench's request sequences can show those behaviours.

// File: rtl/home_dir_pkg.sv
package home_dir_pkg;

  typedef enum logic [1:0] {
    OP_READ = 2'd0,
    OP_RDX  = 2'd1,
    OP_WB   = 2'd2,
    OP_DONE = 2'd3
  } req_op_e;

  typedef enum logic [2:0] {
    M_DATA    = 3'd0,
    M_GRANT   = 3'd1,
    M_NAK     = 3'd2,
    M_WBACK   = 3'd3,
    M_FWD_RD  = 3'd4,
    M_FWD_RDX = 3'd5,
    M_INV     = 3'd6
  } msg_e;

  localparam int unsigned MSG_W = 3;

endpackage

// File: rtl/home_dir_ram.sv
module home_dir_ram #(
  parameter int unsigned NODES  = 16,
  parameter int unsigned BLOCKS = 64,
  localparam int unsigned BW = $clog2(BLOCKS),
  localparam int unsigned IW = $clog2(NODES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BW-1:0]    rd_idx,
  output logic             rd_dirty,
  output logic [NODES-1:0] rd_vec,
  output logic             rd_pend,
  output logic             rd_pkind,
  output logic [IW-1:0]    rd_preq,
  input  logic             wr_en,
  input  logic [BW-1:0]    wr_idx,
  input  logic             wr_dirty,
  input  logic [NODES-1:0] wr_vec,
  input  logic             wr_pend,
  input  logic             wr_pkind,
  input  logic [IW-1:0]    wr_preq
);

  logic             dirty_q [BLOCKS];
  logic [NODES-1:0] vec_q   [BLOCKS];
  logic             pend_q  [BLOCKS];
  logic             pkind_q [BLOCKS];
  logic [IW-1:0]    preq_q  [BLOCKS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < BLOCKS; i++) begin
        dirty_q[i] <= 1'b0;
        vec_q[i]   <= '0;
        pend_q[i]  <= 1'b0;
        pkind_q[i] <= 1'b0;
        preq_q[i]  <= '0;
      end
    end else if (wr_en) begin
      dirty_q[wr_idx] <= wr_dirty;
      vec_q[wr_idx]   <= wr_vec;
      pend_q[wr_idx]  <= wr_pend;
      pkind_q[wr_idx] <= wr_pkind;
      preq_q[wr_idx]  <= wr_preq;
    end
  end

  assign rd_dirty = dirty_q[rd_idx];
  assign rd_vec   = vec_q[rd_idx];
  assign rd_pend  = pend_q[rd_idx];
  assign rd_pkind = pkind_q[rd_idx];
  assign rd_preq  = preq_q[rd_idx];

endmodule

// File: rtl/home_dir_decide.sv
module home_dir_decide
  import home_dir_pkg::*;
#(
  parameter int unsigned NODES = 16,
  localparam int unsigned IW = $clog2(NODES)
) (
  input  logic [1:0]       op,
  input  logic [IW-1:0]    src,
  input  logic             e_dirty,
  input  logic [NODES-1:0] e_vec,
  input  logic             e_pend,
  input  logic             e_pkind,
  input  logic [IW-1:0]    e_preq,
  output logic             use_rp,
  output logic [2:0]       rp_type,
  output logic [IW-1:0]    rp_dest,
  output logic             use_rq,
  output logic [2:0]       rq_type,
  output logic [IW-1:0]    rq_dest,
  output logic [NODES-1:0] inv_mask,
  output logic             upd,
  output logic             n_dirty,
  output logic [NODES-1:0] n_vec,
  output logic             n_pend,
  output logic             n_pkind,
  output logic [IW-1:0]    n_preq
);

  localparam logic [NODES-1:0] ONE = {{(NODES-1){1'b0}}, 1'b1};

  logic [IW-1:0]    owner;
  logic [NODES-1:0] src_bit;
  logic [NODES-1:0] preq_bit;
  logic             src_owns;

  always_comb begin
    owner = '0;
    for (int i = NODES - 1; i >= 0; i--) begin
      if (e_vec[i]) owner = IW'(i);
    end
  end

  assign src_bit  = ONE << src;
  assign preq_bit = ONE << e_preq;
  assign src_owns = e_dirty && e_vec[src];

  always_comb begin
    use_rp   = 1'b0;
    rp_type  = M_NAK;
    rp_dest  = src;
    use_rq   = 1'b0;
    rq_type  = M_FWD_RD;
    rq_dest  = owner;
    inv_mask = '0;
    upd      = 1'b0;
    n_dirty  = e_dirty;
    n_vec    = e_vec;
    n_pend   = e_pend;
    n_pkind  = e_pkind;
    n_preq   = e_preq;
    case (req_op_e'(op))
      OP_READ: begin
        if (e_pend) begin
          use_rp = 1'b1;
        end else if (e_dirty) begin
          use_rq  = 1'b1;
          rq_type = M_FWD_RD;
          upd     = 1'b1;
          n_pend  = 1'b1;
          n_pkind = 1'b0;
          n_preq  = src;
        end else begin
          use_rp  = 1'b1;
          rp_type = M_DATA;
          upd     = 1'b1;
          n_vec   = e_vec | src_bit;
        end
      end
      OP_RDX: begin
        if (e_pend) begin
          use_rp = 1'b1;
        end else if (e_dirty) begin
          use_rq  = 1'b1;
          rq_type = M_FWD_RDX;
          upd     = 1'b1;
          n_pend  = 1'b1;
          n_pkind = 1'b1;
          n_preq  = src;
        end else begin
          use_rp   = 1'b1;
          rp_type  = M_GRANT;
          inv_mask = e_vec & ~src_bit;
          upd      = 1'b1;
          n_dirty  = 1'b1;
          n_vec    = src_bit;
        end
      end
      OP_WB: begin
        use_rp = 1'b1;
        if (!e_pend && src_owns) begin
          rp_type = M_WBACK;
          upd     = 1'b1;
          n_dirty = 1'b0;
          n_vec   = '0;
        end
      end
      default: begin
        if (e_pend && e_vec[src]) begin
          upd    = 1'b1;
          n_pend = 1'b0;
          if (e_pkind) begin
            n_dirty = 1'b1;
            n_vec   = preq_bit;
          end else begin
            n_dirty = 1'b0;
            n_vec   = e_vec | preq_bit;
          end
        end
      end
    endcase
  end

endmodule

// File: rtl/home_dir_slot.sv
module home_dir_slot #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  output logic         free,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  logic         valid_q, valid_d;
  logic [W-1:0] data_q;

  assign free = !valid_q || out_ready;

  always_comb begin
    valid_d = valid_q;
    if (load)           valid_d = 1'b1;
    else if (out_ready) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    data_q <= '0;
    else if (load) data_q <= load_data;
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;

endmodule

// File: rtl/home_dir_invseq.sv
module home_dir_invseq #(
  parameter int unsigned NODES  = 16,
  parameter int unsigned BLOCKS = 64,
  localparam int unsigned BW = $clog2(BLOCKS),
  localparam int unsigned IW = $clog2(NODES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NODES-1:0] start_mask,
  input  logic [BW-1:0]    start_blk,
  input  logic [IW-1:0]    start_req,
  input  logic             slot_free,
  output logic             idle,
  output logic             emit,
  output logic [IW-1:0]    emit_dest,
  output logic [BW-1:0]    emit_blk,
  output logic [IW-1:0]    emit_req
);

  logic [NODES-1:0] mask_q, mask_d, low_bit;
  logic [BW-1:0]    blk_q;
  logic [IW-1:0]    req_q;

  assign idle    = (mask_q == '0);
  assign emit    = !idle && slot_free;
  assign low_bit = mask_q & (~mask_q + 1'b1);

  always_comb begin
    emit_dest = '0;
    for (int i = 0; i < NODES; i++) begin
      if (low_bit[i]) emit_dest = IW'(i);
    end
  end

  always_comb begin
    mask_d = mask_q;
    if (start)     mask_d = start_mask;
    else if (emit) mask_d = mask_q & ~low_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q <= '0;
      req_q <= '0;
    end else if (start) begin
      blk_q <= start_blk;
      req_q <= start_req;
    end
  end

  assign emit_blk = blk_q;
  assign emit_req = req_q;

endmodule

// File: rtl/home_dir_ctrl.sv
module home_dir_ctrl
  import home_dir_pkg::*;
#(
  parameter int unsigned NODES  = 16,
  parameter int unsigned BLOCKS = 64,
  localparam int unsigned BW = $clog2(BLOCKS),
  localparam int unsigned IW = $clog2(NODES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [BW-1:0] req_blk,
  input  logic [IW-1:0] req_src,
  output logic          rp_valid,
  input  logic          rp_ready,
  output logic [2:0]    rp_type,
  output logic [IW-1:0] rp_dest,
  output logic [BW-1:0] rp_blk,
  output logic          rq_valid,
  input  logic          rq_ready,
  output logic [2:0]    rq_type,
  output logic [IW-1:0] rq_dest,
  output logic [BW-1:0] rq_blk,
  output logic [IW-1:0] rq_req
);

  localparam int unsigned RPW = MSG_W + IW + BW;
  localparam int unsigned RQW = MSG_W + IW + BW + IW;

  // reset: asserted at once, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  // directory lookup
  logic             e_dirty, e_pend, e_pkind;
  logic [NODES-1:0] e_vec;
  logic [IW-1:0]    e_preq;

  logic             use_rp, use_rq, upd;
  logic [2:0]       d_rp_type, d_rq_type;
  logic [IW-1:0]    d_rp_dest, d_rq_dest;
  logic [NODES-1:0] inv_mask;
  logic             wr_dirty, wr_pend, wr_pkind;
  logic [NODES-1:0] wr_vec;
  logic [IW-1:0]    wr_preq;
  logic             dir_wr_en;

  logic rp_free, rq_free, seq_idle, seq_emit;
  logic [IW-1:0] seq_dest, seq_req;
  logic [BW-1:0] seq_blk;
  logic inv_any, rp_ok, rq_ok, accept;

  home_dir_ram #(.NODES(NODES), .BLOCKS(BLOCKS)) ram_i (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .rd_idx   (req_blk),
    .rd_dirty (e_dirty),
    .rd_vec   (e_vec),
    .rd_pend  (e_pend),
    .rd_pkind (e_pkind),
    .rd_preq  (e_preq),
    .wr_en    (dir_wr_en),
    .wr_idx   (req_blk),
    .wr_dirty (wr_dirty),
    .wr_vec   (wr_vec),
    .wr_pend  (wr_pend),
    .wr_pkind (wr_pkind),
    .wr_preq  (wr_preq)
  );

  home_dir_decide #(.NODES(NODES)) decide_i (
    .op       (req_op),
    .src      (req_src),
    .e_dirty  (e_dirty),
    .e_vec    (e_vec),
    .e_pend   (e_pend),
    .e_pkind  (e_pkind),
    .e_preq   (e_preq),
    .use_rp   (use_rp),
    .rp_type  (d_rp_type),
    .rp_dest  (d_rp_dest),
    .use_rq   (use_rq),
    .rq_type  (d_rq_type),
    .rq_dest  (d_rq_dest),
    .inv_mask (inv_mask),
    .upd      (upd),
    .n_dirty  (wr_dirty),
    .n_vec    (wr_vec),
    .n_pend   (wr_pend),
    .n_pkind  (wr_pkind),
    .n_preq   (wr_preq)
  );

  // intake: each request waits only on the channel(s) its answer uses
  assign inv_any   = |inv_mask;
  assign rp_ok     = !use_rp || rp_free;
  assign rq_ok     = !(use_rq || inv_any) || (rq_free && seq_idle);
  assign req_ready = core_rst_n && rp_ok && rq_ok;
  assign accept    = req_valid && req_ready;
  assign dir_wr_en = accept && upd;

  logic [RPW-1:0] rp_word;
  home_dir_slot #(.W(RPW)) rp_slot_i (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .load      (accept && use_rp),
    .load_data ({d_rp_type, d_rp_dest, req_blk}),
    .free      (rp_free),
    .out_valid (rp_valid),
    .out_ready (rp_ready),
    .out_data  (rp_word)
  );
  assign {rp_type, rp_dest, rp_blk} = rp_word;

  home_dir_invseq #(.NODES(NODES), .BLOCKS(BLOCKS)) seq_i (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .start      (accept && inv_any),
    .start_mask (inv_mask),
    .start_blk  (req_blk),
    .start_req  (req_src),
    .slot_free  (rq_free),
    .idle       (seq_idle),
    .emit       (seq_emit),
    .emit_dest  (seq_dest),
    .emit_blk   (seq_blk),
    .emit_req   (seq_req)
  );

  logic [RQW-1:0] rq_in, rq_word;
  always_comb begin
    if (seq_emit) rq_in = {M_INV, seq_dest, seq_blk, seq_req};
    else          rq_in = {d_rq_type, d_rq_dest, req_blk, req_src};
  end

  home_dir_slot #(.W(RQW)) rq_slot_i (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .load      ((accept && use_rq) || seq_emit),
    .load_data (rq_in),
    .free      (rq_free),
    .out_valid (rq_valid),
    .out_ready (rq_ready),
    .out_data  (rq_word)
  );
  assign {rq_type, rq_dest, rq_blk, rq_req} = rq_word;

endmodule

// File: rtl/home_dir_chk.sv
module home_dir_chk #(
  parameter int unsigned NODES  = 16,
  parameter int unsigned BLOCKS = 64,
  localparam int unsigned BW = $clog2(BLOCKS),
  localparam int unsigned IW = $clog2(NODES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [1:0]       req_op,
  input logic             rp_valid,
  input logic             rp_ready,
  input logic [2:0]       rp_type,
  input logic [IW-1:0]    rp_dest,
  input logic [BW-1:0]    rp_blk,
  input logic             rq_valid,
  input logic             rq_ready,
  input logic [2:0]       rq_type,
  input logic [IW-1:0]    rq_dest,
  input logic [BW-1:0]    rq_blk,
  input logic [IW-1:0]    rq_req,
  input logic             dir_wr_en,
  input logic             wr_dirty,
  input logic [NODES-1:0] wr_vec
);

  // R10
  rp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rp_valid && !rp_ready |=> rp_valid && $stable(rp_type) && $stable(rp_dest) && $stable(rp_blk));

  // R10
  rq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid && !rq_ready |=> rq_valid && $stable(rq_type) && $stable(rq_dest)
                              && $stable(rq_blk) && $stable(rq_req));

  // R10
  rp_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rp_valid |-> rp_type <= 3'd3);

  // R10
  rq_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid |-> (rq_type >= 3'd4) && (rq_type <= 3'd6));

  // R5
  inv_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid && rq_type == 3'd6 |-> rq_dest != rq_req);

  // R8
  answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_op != 2'd3 |=> rp_valid || rq_valid);

  // R6
  sole_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dir_wr_en && wr_dirty |-> $countones(wr_vec) == 1);

endmodule

bind home_dir_ctrl home_dir_chk #(.NODES(NODES), .BLOCKS(BLOCKS)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_op    (req_op),
  .rp_valid  (rp_valid),
  .rp_ready  (rp_ready),
  .rp_type   (rp_type),
  .rp_dest   (rp_dest),
  .rp_blk    (rp_blk),
  .rq_valid  (rq_valid),
  .rq_ready  (rq_ready),
  .rq_type   (rq_type),
  .rq_dest   (rq_dest),
  .rq_blk    (rq_blk),
  .rq_req    (rq_req),
  .dir_wr_en (dir_wr_en),
  .wr_dirty  (wr_dirty),
  .wr_vec    (wr_vec)
);

// File: tb/home_dir_ctrl_tb_top.sv
module home_dir_ctrl_tb_top;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned NODES  = 16;
  localparam int unsigned BLOCKS = 64;
  localparam int unsigned BW = $clog2(BLOCKS);
  localparam int unsigned IW = $clog2(NODES);
  localparam int unsigned NVEC = 21;

  // {op[31:30], blk[29:24], src[23:20], rp_v[19], rp_t[18:16], rp_d[15:12],
  //  rq_v[11], rq_t[10:8], rq_d[7:4], tag[3:0]}
  localparam logic [31:0] VECS [NVEC] = '{
    {2'd0, 6'd5,  4'd3,  1'b1, 3'd0, 4'd3,  1'b0, 3'd0, 4'd0, 4'd2},  // R2 read uncached
    {2'd0, 6'd5,  4'd7,  1'b1, 3'd0, 4'd7,  1'b0, 3'd0, 4'd0, 4'd2},  // R2 read shared
    {2'd2, 6'd5,  4'd3,  1'b1, 3'd2, 4'd3,  1'b0, 3'd0, 4'd0, 4'd7},  // R7 wb on shared block
    {2'd1, 6'd9,  4'd2,  1'b1, 3'd1, 4'd2,  1'b0, 3'd0, 4'd0, 4'd5},  // R5 rdx, no sharers
    {2'd0, 6'd9,  4'd4,  1'b0, 3'd0, 4'd0,  1'b1, 3'd4, 4'd2, 4'd3},  // R3 read forwarded
    {2'd0, 6'd9,  4'd6,  1'b1, 3'd2, 4'd6,  1'b0, 3'd0, 4'd0, 4'd8},  // R8 busy block
    {2'd0, 6'd5,  4'd8,  1'b1, 3'd0, 4'd8,  1'b0, 3'd0, 4'd0, 4'd8},  // R8 other block goes on
    {2'd2, 6'd9,  4'd2,  1'b1, 3'd2, 4'd2,  1'b0, 3'd0, 4'd0, 4'd8},  // R8 wb while busy
    {2'd3, 6'd9,  4'd2,  1'b0, 3'd0, 4'd0,  1'b0, 3'd0, 4'd0, 4'd4},  // R4 completion
    {2'd3, 6'd9,  4'd2,  1'b0, 3'd0, 4'd0,  1'b0, 3'd0, 4'd0, 4'd9},  // R9 stray completion
    {2'd0, 6'd9,  4'd11, 1'b1, 3'd0, 4'd11, 1'b0, 3'd0, 4'd0, 4'd9},  // R9 entry still shared
    {2'd1, 6'd12, 4'd1,  1'b1, 3'd1, 4'd1,  1'b0, 3'd0, 4'd0, 4'd5},  // R5 grant
    {2'd1, 6'd12, 4'd5,  1'b0, 3'd0, 4'd0,  1'b1, 3'd5, 4'd1, 4'd6},  // R6 exclusive forward
    {2'd3, 6'd12, 4'd1,  1'b0, 3'd0, 4'd0,  1'b0, 3'd0, 4'd0, 4'd6},  // R6 ownership update
    {2'd0, 6'd12, 4'd9,  1'b0, 3'd0, 4'd0,  1'b1, 3'd4, 4'd5, 4'd6},  // R6 new owner is 5
    {2'd3, 6'd12, 4'd5,  1'b0, 3'd0, 4'd0,  1'b0, 3'd0, 4'd0, 4'd4},  // R4 sharing write-back
    {2'd2, 6'd12, 4'd5,  1'b1, 3'd2, 4'd5,  1'b0, 3'd0, 4'd0, 4'd7},  // R7 no longer owner
    {2'd1, 6'd20, 4'd0,  1'b1, 3'd1, 4'd0,  1'b0, 3'd0, 4'd0, 4'd7},  // R7 make owner
    {2'd2, 6'd20, 4'd0,  1'b1, 3'd3, 4'd0,  1'b0, 3'd0, 4'd0, 4'd7},  // R7 owner wb
    {2'd0, 6'd20, 4'd0,  1'b1, 3'd0, 4'd0,  1'b0, 3'd0, 4'd0, 4'd7},  // R7 block uncached
    {2'd3, 6'd20, 4'd0,  1'b0, 3'd0, 4'd0,  1'b0, 3'd0, 4'd0, 4'd9}   // R9 completion, not busy
  };

  logic          clk;
  logic          rst_n;
  logic          req_valid, req_ready;
  logic [1:0]    req_op;
  logic [BW-1:0] req_blk;
  logic [IW-1:0] req_src;
  logic          rp_valid, rp_ready;
  logic [2:0]    rp_type;
  logic [IW-1:0] rp_dest;
  logic [BW-1:0] rp_blk;
  logic          rq_valid, rq_ready;
  logic [2:0]    rq_type;
  logic [IW-1:0] rq_dest;
  logic [BW-1:0] rq_blk;
  logic [IW-1:0] rq_req;

  int n_chk;
  int n_fail;

  home_dir_ctrl #(.NODES(NODES), .BLOCKS(BLOCKS)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_op    (req_op),
    .req_blk   (req_blk),
    .req_src   (req_src),
    .rp_valid  (rp_valid),
    .rp_ready  (rp_ready),
    .rp_type   (rp_type),
    .rp_dest   (rp_dest),
    .rp_blk    (rp_blk),
    .rq_valid  (rq_valid),
    .rq_ready  (rq_ready),
    .rq_type   (rq_type),
    .rq_dest   (rq_dest),
    .rq_blk    (rq_blk),
    .rq_req    (rq_req)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input int tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // present one request; returns at the falling edge after it was taken
  task automatic send(input logic [1:0] op, input int blk, input int src);
    req_op    = op;
    req_blk   = BW'(blk);
    req_src   = IW'(src);
    req_valid = 1'b1;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_inv(input int tag, input int dest, input int blk, input int who);
    @(negedge clk);
    check(tag, "inv valid", int'(rq_valid), 1);
    check(tag, "inv type", int'(rq_type), 6);
    check(tag, "inv dest", int'(rq_dest), dest);
    check(tag, "inv blk", int'(rq_blk), blk);
    check(tag, "inv requester", int'(rq_req), who);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL R10 watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    n_chk     = 0;
    n_fail    = 0;
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_op    = '0;
    req_blk   = '0;
    req_src   = '0;
    rp_ready  = 1'b1;
    rq_ready  = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 idle after reset and ready to take a request
    #1;
    check(1, "reset rp_valid", int'(rp_valid), 0);
    check(1, "reset rq_valid", int'(rq_valid), 0);
    check(1, "reset req_ready", int'(req_ready), 1);
    send(2'd0, 33, 6);
    check(1, "reset entry answers with data", int'(rp_type), 0);
    check(1, "reset entry rq idle", int'(rq_valid), 0);

    // table walk
    for (int k = 0; k < NVEC; k++) begin
      logic [31:0] v;
      int tag;
      v   = VECS[k];
      tag = int'(v[3:0]);
      send(v[31:30], int'(v[29:24]), int'(v[23:20]));
      check(tag, "rp_valid", int'(rp_valid), int'(v[19]));
      if (v[19]) begin
        check(tag, "rp_type", int'(rp_type), int'(v[18:16]));
        check(tag, "rp_dest", int'(rp_dest), int'(v[15:12]));
        check(tag, "rp_blk", int'(rp_blk), int'(v[29:24]));
      end
      check(tag, "rq_valid", int'(rq_valid), int'(v[11]));
      if (v[11]) begin
        check(tag, "rq_type", int'(rq_type), int'(v[10:8]));
        check(tag, "rq_dest", int'(rq_dest), int'(v[7:4]));
        check(tag, "rq_req", int'(rq_req), int'(v[23:20]));
      end
    end

    // R5 block 5 shared by 3, 7, 8: node 7 takes it; 3 then 8 invalidated
    send(2'd1, 5, 7);
    check(5, "grant type", int'(rp_type), 1);
    check(5, "grant dest", int'(rp_dest), 7);
    check(5, "no inv yet", int'(rq_valid), 0);
    expect_inv(5, 3, 5, 7);
    expect_inv(5, 8, 5, 7);
    @(negedge clk);
    check(5, "inv train ended", int'(rq_valid), 0);

    // R4 block 12 shared by old owner 5 and reader 9: node 9 takes it
    send(2'd1, 12, 9);
    check(4, "grant dest", int'(rp_dest), 9);
    expect_inv(4, 5, 12, 9);
    @(negedge clk);
    check(4, "single inv", int'(rq_valid), 0);

    // R4 block 9 shared by 2, 4 and 11: node 4 takes it
    send(2'd1, 9, 4);
    check(4, "grant type", int'(rp_type), 1);
    expect_inv(4, 2, 9, 4);
    expect_inv(4, 11, 9, 4);
    @(negedge clk);
    check(4, "inv train ended", int'(rq_valid), 0);

    // R10 blocked reply channel; block 5 is owned by 7
    rp_ready = 1'b0;
    send(2'd0, 40, 1);
    check(10, "held data valid", int'(rp_valid), 1);
    send(2'd0, 5, 2);
    check(10, "forward passes blocked reply", int'(rq_type), 4);
    check(10, "forward dest", int'(rq_dest), 7);
    check(10, "reply held dest", int'(rp_dest), 1);
    check(10, "reply held blk", int'(rp_blk), 40);
    req_op    = 2'd0;
    req_blk   = BW'(41);
    req_src   = IW'(3);
    req_valid = 1'b1;
    #1;
    check(10, "reply-bound request stalls", int'(req_ready), 0);
    repeat (3) @(negedge clk);
    check(10, "reply still held", int'(rp_dest), 1);
    check(10, "reply type held", int'(rp_type), 0);
    rp_ready = 1'b1;
    send(2'd0, 41, 3);
    check(10, "stalled request answered", int'(rp_dest), 3);
    check(10, "stalled request blk", int'(rp_blk), 41);

    // R8 block 5 busy with the forward from node 2
    send(2'd1, 5, 9);
    check(8, "busy rdx nak", int'(rp_type), 2);
    send(2'd3, 5, 7);
    send(2'd0, 5, 10);
    check(3, "after completion data", int'(rp_type), 0);
    check(3, "after completion dest", int'(rp_dest), 10);

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end

endmodule